// File: doc/BRIEF.md
# Card Slot Power Sequencer

This block decides when a hot-plug card slot gets power. It drives three switched supply rails: an auxiliary rail, a main high-voltage rail and a main low-voltage rail. Each rail has a switch enable and a discharge enable. The decision comes from three sources: the health of the host input rails, the card-detect pins, and the host's shutdown and standby requests. The analog parts are outside the block. Switching, current limit, voltage and temperature sensing reach it only as digital "good" flags.

Once the powered slot has had every output rail good for a programmable settling time, the block releases a slot reset. Between the slot being powered and the reset being released, the block also controls a bidirectional reference-clock-enable pin. The block pulls that pin low while the slot is not fully powered. An outside agent can also hold the pin low, and doing so keeps the slot in reset.

All pins pass through two-flop synchronizers. All delays are counted in clock cycles and derived from a clock-frequency parameter. The current mode is reported on a small encoded output.

Top module: `slot_power_seq`

## Requirements
- R1: When the synchronized auxiliary input flag is low, the mode is OFF (code 0) and every switch enable and every discharge enable is low, whatever the other inputs are.
- R2: With auxiliary input good and `shdn_n` low, the mode is SHUTDOWN (code 1), all switches are off and all three discharge enables are high. Raising `shdn_n` brings the block back to the mode it held before shutdown, including standby with the main inputs still absent.
- R3: A card is present when `card_a_n` or `card_b_n` is low. With both pins high, the mode is UNPOWERED (code 2), all switches are off and all discharge enables are high.
- R4: The mode is ACTIVE (code 4) and all three switches are on with no discharge when all of the following hold: all three input flags good, a card present, `shdn_n` high and `stby_n` high.
- R5: From ACTIVE, the mode becomes STANDBY (code 3) in either of two cases: `stby_n` goes low, or either main input flag drops while the card stays. In STANDBY only the auxiliary switch is on, and no discharge enable is high.
- R6: A card that arrives while a main input is absent, or while `stby_n` is low, and that was not powered before, leaves the mode UNPOWERED with no switch on.
- R7: `slot_rst_n` is low in every mode other than ACTIVE. It falls within three clock edges of `host_rst_n` going low or of any output-good flag going low.
- R8: `slot_rst_n` rises only after the mode has been ACTIVE with all three output flags good for GOOD_DELAY_US microseconds of clock cycles, and only while `host_rst_n` is high.
- R9: `refclk_en_pull_low` is high whenever the slot is not ACTIVE with all outputs good. It drops in the same cycle that condition becomes true. A low level sensed on `refclk_en_pin` holds `slot_rst_n` low.
- R10: Every low pulse of `slot_rst_n` lasts at least MIN_RST_US microseconds of clock cycles, even when its cause goes away sooner.
- R11: Every pin input acts only after two synchronizer stages, so a mode change appears at the third rising edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_in_ok | input | 1 | Auxiliary input rail above threshold |
| main_hi_in_ok | input | 1 | Main high-voltage input rail good |
| main_lo_in_ok | input | 1 | Main low-voltage input rail good |
| aux_out_ok | input | 1 | Auxiliary output within tolerance |
| main_hi_out_ok | input | 1 | Main high-voltage output within tolerance |
| main_lo_out_ok | input | 1 | Main low-voltage output within tolerance |
| card_a_n | input | 1 | First card-detect pin, low when a card is present |
| card_b_n | input | 1 | Second card-detect pin, low when a card is present |
| shdn_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| host_rst_n | input | 1 | Host system reset, active low |
| refclk_en_pin | input | 1 | Sensed level of the reference-clock-enable pin |
| aux_sw_en | output | 1 | Auxiliary switch on |
| main_hi_sw_en | output | 1 | Main high-voltage switch on |
| main_lo_sw_en | output | 1 | Main low-voltage switch on |
| aux_dis_en | output | 1 | Auxiliary output discharge on |
| main_hi_dis_en | output | 1 | Main high-voltage output discharge on |
| main_lo_dis_en | output | 1 | Main low-voltage output discharge on |
| slot_rst_n | output | 1 | Delayed reset to the card, active low |
| refclk_en_pull_low | output | 1 | Open-drain pull-down of the reference-clock-enable pin |
| mode | output | 3 | Encoded mode: 0 off, 1 shutdown, 2 unpowered, 3 standby, 4 active |

## Verification
The minimum-width rule for the slot reset and the release gate meet at the same clock edge. This happens when the cause of a reset is gone well before the pulse has met its minimum length. The bench provokes it two ways. One is a single-cycle `host_rst_n` glitch while the slot is fully released. The other is a short external hold on the clock-enable pin. In both, settling has already finished, so only the pulse timer can keep the reset low. A behavioural model compares the exact cycle of the rising edge on every clock. Shutdown taken from standby with the main rails still missing is a second such case: the remembered mode and the live rail state disagree, and the resumed mode must follow memory.

// File: rtl/slot_power_seq.sv
module slot_power_seq #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int GOOD_DELAY_US = 10_000,
  parameter int MIN_RST_US    = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_in_ok,
  input  logic       main_hi_in_ok,
  input  logic       main_lo_in_ok,
  input  logic       aux_out_ok,
  input  logic       main_hi_out_ok,
  input  logic       main_lo_out_ok,
  input  logic       card_a_n,
  input  logic       card_b_n,
  input  logic       shdn_n,
  input  logic       stby_n,
  input  logic       host_rst_n,
  input  logic       refclk_en_pin,
  output logic       aux_sw_en,
  output logic       main_hi_sw_en,
  output logic       main_lo_sw_en,
  output logic       aux_dis_en,
  output logic       main_hi_dis_en,
  output logic       main_lo_dis_en,
  output logic       slot_rst_n,
  output logic       refclk_en_pull_low,
  output logic [2:0] mode
);
  localparam longint GOOD_L   = (64'(CLK_HZ) * 64'(GOOD_DELAY_US)) / 64'd1_000_000;
  localparam longint MINR_L   = (64'(CLK_HZ) * 64'(MIN_RST_US)) / 64'd1_000_000;
  localparam int     GOOD_CYC = (GOOD_L < 2) ? 2 : int'(GOOD_L);
  localparam int     MIN_CYC  = (MINR_L < 1) ? 1 : int'(MINR_L);
  localparam int     GW       = $clog2(GOOD_CYC + 1);
  localparam int     MW       = $clog2(MIN_CYC + 1);
  localparam int     NPIN     = 12;

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_SHDN = 3'd1;
  localparam logic [2:0] M_IDLE = 3'd2;
  localparam logic [2:0] M_STBY = 3'd3;
  localparam logic [2:0] M_ACT  = 3'd4;

  logic [NPIN-1:0] sync1, sync2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {refclk_en_pin, host_rst_n, stby_n, shdn_n, card_b_n, card_a_n,
                main_lo_out_ok, main_hi_out_ok, aux_out_ok,
                main_lo_in_ok, main_hi_in_ok, aux_in_ok};
      sync2 <= sync1;
    end
  end

  logic aux_s, mains_s, outs_s, card_s, shdn_s, stby_s, host_s, refclk_s;
  assign aux_s    = sync2[0];
  assign mains_s  = sync2[1] & sync2[2];
  assign outs_s   = &sync2[5:3];
  assign card_s   = ~(sync2[6] & sync2[7]);
  assign shdn_s   = sync2[8];
  assign stby_s   = sync2[9];
  assign host_s   = sync2[10];
  assign refclk_s = sync2[11];

  logic [2:0] mode_q, base_q, mode_d, base_d;
  always_comb begin
    base_d = base_q;
    mode_d = M_SHDN;
    if (!aux_s) begin
      base_d = M_OFF;
      mode_d = M_OFF;
    end else if (shdn_s) begin
      if (!card_s)                              base_d = M_IDLE;
      else if (mains_s && stby_s)               base_d = M_ACT;
      else if (base_q == M_ACT || base_q == M_STBY) base_d = M_STBY;
      else                                      base_d = M_IDLE;
      mode_d = base_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      base_q <= M_OFF;
    end else begin
      mode_q <= mode_d;
      base_q <= base_d;
    end
  end

  assign mode           = mode_q;
  assign aux_sw_en      = (mode_q == M_ACT) || (mode_q == M_STBY);
  assign main_hi_sw_en  = (mode_q == M_ACT);
  assign main_lo_sw_en  = (mode_q == M_ACT);
  assign aux_dis_en     = (mode_q == M_SHDN) || (mode_q == M_IDLE);
  assign main_hi_dis_en = aux_dis_en;
  assign main_lo_dis_en = aux_dis_en;

  logic pwr_good;
  assign pwr_good           = (mode_q == M_ACT) && outs_s;
  assign refclk_en_pull_low = ~pwr_good;

  logic [GW-1:0] good_cnt;
  logic [MW-1:0] low_cnt;
  logic          rst_q, release_ok;

  assign release_ok = pwr_good && (good_cnt == GW'(GOOD_CYC)) && host_s && refclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_cnt <= '0;
      low_cnt  <= '0;
      rst_q    <= 1'b0;
    end else begin
      if (!pwr_good)                       good_cnt <= '0;
      else if (good_cnt != GW'(GOOD_CYC))  good_cnt <= good_cnt + 1'b1;
      if (rst_q)                           low_cnt <= '0;
      else if (low_cnt != MW'(MIN_CYC))    low_cnt <= low_cnt + 1'b1;
      if (!release_ok)                     rst_q <= 1'b0;
      else if (low_cnt == MW'(MIN_CYC))    rst_q <= 1'b1;
    end
  end
  assign slot_rst_n = rst_q;

  AST_AUX_LOSS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_s |=> !(aux_sw_en | main_hi_sw_en | main_lo_sw_en | aux_dis_en | main_hi_dis_en | main_lo_dis_en)); // R1
  AST_SHDN_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_s && !shdn_s) |=> (aux_dis_en && main_hi_dis_en && main_lo_dis_en && !aux_sw_en && !main_hi_sw_en && !main_lo_sw_en)); // R2
  AST_STBY_ONLY_FROM_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY) |-> $past(mode_q == M_ACT || mode_q == M_STBY || mode_q == M_SHDN)); // R6
  AST_HOST_RST_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !host_s |=> !slot_rst_n); // R7
  AST_RELEASE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n |-> $past(mode_q == M_ACT)); // R8
  AST_PIN_HOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !refclk_s |=> !slot_rst_n); // R9
endmodule

// File: tb/slot_power_seq_test.sv
module slot_power_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 100_000;
  localparam int GOOD       = 1000;
  localparam int MINLO      = 10;

  logic clk = 0, rst_n = 0;
  logic aux_i = 0, hi_i = 1, lo_i = 1, auxo = 1, hio = 1, loo = 1;
  logic ca = 1, cb = 1, sd = 1, sb = 1, hr = 1, ext_hold = 0;
  logic pin;
  logic aux_sw, hi_sw, lo_sw, aux_dis, hi_dis, lo_dis, srst_n, pull_low;
  logic [2:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin = !pull_low && !ext_hold;

  slot_power_seq #(.CLK_HZ(HZ), .GOOD_DELAY_US(10_000), .MIN_RST_US(100)) uut (
    .clk(clk), .rst_n(rst_n),
    .aux_in_ok(aux_i), .main_hi_in_ok(hi_i), .main_lo_in_ok(lo_i),
    .aux_out_ok(auxo), .main_hi_out_ok(hio), .main_lo_out_ok(loo),
    .card_a_n(ca), .card_b_n(cb), .shdn_n(sd), .stby_n(sb), .host_rst_n(hr),
    .refclk_en_pin(pin),
    .aux_sw_en(aux_sw), .main_hi_sw_en(hi_sw), .main_lo_sw_en(lo_sw),
    .aux_dis_en(aux_dis), .main_hi_dis_en(hi_dis), .main_lo_dis_en(lo_dis),
    .slot_rst_n(srst_n), .refclk_en_pull_low(pull_low), .mode(mode));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, R11 latency of two stages
  logic [11:0] d1 = '0, d2 = '0;
  int m_mode = 0, m_base = 0, m_good = 0, m_low = 0;
  bit m_rst = 0;

  always @(posedge clk) begin
    int nb, nm;
    bit present, pg, rel;
    if (!rst_n) begin
      d1 <= '0; d2 <= '0; m_mode <= 0; m_base <= 0; m_good <= 0; m_low <= 0; m_rst <= 0;
    end else begin
      present = !(d2[6] && d2[7]);
      nb = m_base;
      if (!d2[0]) begin nb = 0; nm = 0; end
      else if (!d2[8]) nm = 1;
      else begin
        if (!present) nb = 2;
        else if (d2[1] && d2[2] && d2[9]) nb = 4;
        else if (m_base >= 3) nb = 3;
        else nb = 2;
        nm = nb;
      end
      pg  = (m_mode == 4) && d2[3] && d2[4] && d2[5];
      rel = pg && (m_good == GOOD) && d2[10] && d2[11];
      m_good <= !pg ? 0 : (m_good < GOOD ? m_good + 1 : m_good);
      m_low  <= m_rst ? 0 : (m_low < MINLO ? m_low + 1 : m_low);
      if (!rel) m_rst <= 0; else if (m_low == MINLO) m_rst <= 1;
      m_mode <= nm; m_base <= nb;
      d1 <= {pin, hr, sb, sd, cb, ca, loo, hio, auxo, lo_i, hi_i, aux_i};
      d2 <= d1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t;
      bit pg;
      case (m_mode)
        0: t = "R1"; 1: t = "R2"; 2: t = "R3"; 3: t = "R5"; default: t = "R4";
      endcase
      pg = (m_mode == 4) && d2[3] && d2[4] && d2[5];
      chk({t, " mode"}, mode, m_mode);
      chk({t, " switches"}, {aux_sw, hi_sw, lo_sw},
          {m_mode >= 3, m_mode == 4, m_mode == 4});
      chk({t, " discharge"}, {aux_dis, hi_dis, lo_dis},
          {3{m_mode == 1 || m_mode == 2}});
      chk("R7 R8 R10 slot reset", srst_n, m_rst);
      chk("R9 clock enable pull", pull_low, !pg);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 reset mode", mode, 0);
    chk("R7 reset slot", srst_n, 0);
    rst_n = 1;
    step(5);
    chk("R1 aux absent float", {aux_sw, aux_dis, hi_dis}, 0);
    aux_i = 1; step(2);
    chk("R11 not yet visible", mode, 0);
    step(1);
    chk("R11 third edge", mode, 2);
    chk("R3 no card discharge", {aux_dis, hi_dis, lo_dis}, 3'b111);
    ca = 0; step(4);
    chk("R4 active", {aux_sw, hi_sw, lo_sw, mode}, {3'b111, 3'd4});
    step(GOOD - 100);
    chk("R8 still held", srst_n, 0);
    chk("R9 pin released", pull_low, 0);
    step(150);
    chk("R8 released", srst_n, 1);
    hr = 0; step(1); hr = 1;
    step(5);
    chk("R10 min pulse low", srst_n, 0);
    step(15);
    chk("R10 released after pulse", srst_n, 1);
    ext_hold = 1; step(4);
    chk("R9 external hold", srst_n, 0);
    chk("R9 no self pull", pull_low, 0);
    ext_hold = 0; step(20);
    chk("R9 hold removed", srst_n, 1);
    hio = 0; step(3);
    chk("R7 out rail fail", srst_n, 0);
    chk("R9 pull on fail", pull_low, 1);
    hio = 1; step(GOOD + 20);
    chk("R8 re-release", srst_n, 1);
    sb = 0; step(4);
    chk("R5 standby request", {aux_sw, hi_sw, lo_sw, mode}, {3'b100, 3'd3});
    chk("R7 standby reset", srst_n, 0);
    sb = 1; step(4);
    chk("R4 back active", mode, 4);
    hi_i = 0; step(4);
    chk("R5 main lost", mode, 3);
    sd = 0; step(4);
    chk("R2 shutdown", {aux_sw, aux_dis, hi_dis, lo_dis, mode}, {4'b0111, 3'd1});
    sd = 1; step(4);
    chk("R2 resume standby", mode, 3);
    hi_i = 1; step(4);
    chk("R4 mains back", mode, 4);
    ca = 1; step(4);
    chk("R3 card removed", mode, 2);
    cb = 0; step(4);
    chk("R3 second pin", mode, 4);
    cb = 1; lo_i = 0; step(4);
    cb = 0; step(4);
    chk("R6 late card no power", {aux_sw, hi_sw, lo_sw, mode}, {3'b000, 3'd2});
    lo_i = 1; step(4);
    chk("R4 mains restored", mode, 4);
    aux_i = 0; step(4);
    chk("R1 aux lost", {aux_sw, hi_sw, aux_dis, hi_dis, lo_dis, mode}, {5'b0, 3'd0});
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    done = 1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule